// File: doc/BRIEF.md
# Register-Range Vector Issue Sequencer

This block expands a single scalar-format ALU instruction into a run of element micro-ops over consecutive architectural registers. Each register has its own small configuration entry: a vector length and an element width. An operand whose length is greater than one names a range of registers starting at that register. An operand whose length is one behaves as an ordinary scalar. Because the length belongs to each register and not to the machine, several vectors of different sizes can live side by side in the one scalar register file.

A decoded instruction (destination, two sources, opcode and a predicate mask) is accepted when the block is idle. The block looks up the three operands' configurations in that cycle. From the next cycle on it emits one micro-op per cycle to a downstream ALU, stepping the register numbers of the vector operands. The forms it covers are element-wise, scalar-with-vector and sequential reduction. A one-cycle done pulse closes every legal instruction. A one-cycle error pulse rejects an instruction whose register range would run off the end of the file.

Top module: `regrange_issue`

## Requirements
- R1: After reset every register's configuration is length 1, element width 0; the block is idle with `in_ready` high and no micro-op, done or error output.
- R2: An instruction whose three operands all have length 1 issues exactly one micro-op carrying the instruction's register numbers and opcode unchanged.
- R3: The element count is the largest effective length among destination, first source and second source, where a stored length of 0 counts as 1. At element i, an operand of length greater than 1 based at rN uses register rN+i.
- R4: A source of length 1 keeps the same register number for every element, whichever source slot it occupies.
- R5: At element i, `uop_we` follows bit i of the predicate mask latched at acceptance. A masked element is still issued, with `uop_we` low.
- R6: When the destination has length 1 and the count exceeds 1, the instruction is a reduction. `uop_rd` stays fixed, and from element 1 on the destination number replaces the second-source slot if that source has length 1, otherwise the first-source slot.
- R7: A configuration write at one clock edge is used by an instruction accepted at the next edge. An instruction already running keeps the lengths it latched.
- R8: If any operand of length greater than 1 would reach beyond the last register (base + count > number of registers), the block issues no micro-op and no done. It raises `err` for one cycle, in the cycle after acceptance, and stays idle.
- R9: Micro-ops for one instruction come in consecutive cycles, starting the cycle after acceptance. `done` pulses in the cycle after the last one. `in_ready` is low while busy, and an instruction offered then is ignored.
- R10: An element whose destination register is r0 has `uop_we` low.
- R11: `uop_width` carries the element width configured for the destination base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_reg | input | 5 | Register whose configuration is written |
| cfg_len | input | 8 | Vector length to store |
| cfg_width | input | 2 | Element width code to store |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can accept an instruction |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| in_op | input | 4 | ALU opcode, passed through |
| in_pred | input | 32 | Predicate mask, bit i gates element i |
| uop_valid | output | 1 | Micro-op present this cycle |
| uop_op | output | 4 | Micro-op opcode |
| uop_rd | output | 5 | Micro-op destination register |
| uop_rs1 | output | 5 | Micro-op first source register |
| uop_rs2 | output | 5 | Micro-op second source register |
| uop_width | output | 2 | Element width for the micro-op |
| uop_we | output | 1 | Result is to be written |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse after the last micro-op |
| err | output | 1 | One-cycle pulse for a rejected instruction |

## Verification
A wrong element counter or latched length shows up at once in `uop_rd` or the source numbers. It also shows as a missing, early or late `done` pulse, which the cycle-exact model notices within one cycle of the deviation. A corrupted reduction or predicate state gives a wrong source slot or write enable on the first affected element. Configuration storage faults only show when an instruction next reads that register. For that reason the sequence rewrites and reuses registers at once, back to back, and while busy.

// File: rtl/regrange_pkg.sv
package regrange_pkg;

  typedef enum logic [1:0] {
    FORM_SCALAR   = 2'd0,
    FORM_ELEMWISE = 2'd1,
    FORM_REDUCE   = 2'd2
  } form_e;

  // A stored length of zero is read as one (R3).
  function automatic int unsigned eff_len(input int unsigned stored);
    return (stored == 0) ? 1 : stored;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // True when base .. base+len-1 stays inside the register file (R8).
  function automatic logic span_fits(input int unsigned base, input int unsigned len,
                                     input int unsigned nreg);
    return (base + len) <= nreg;
  endfunction

endpackage

// File: rtl/regrange_cfg_table.sv
module regrange_cfg_table #(
  parameter int NREG = 32,
  parameter int VL_W = 8,
  parameter int EW_W = 2,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VL_W-1:0]  wr_len,
  input  logic [EW_W-1:0]  wr_width,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [IDX_W-1:0] b_idx,
  output logic [VL_W-1:0]  rd_len,
  output logic [VL_W-1:0]  a_len,
  output logic [VL_W-1:0]  b_len,
  output logic [EW_W-1:0]  rd_width
);

  logic [VL_W-1:0] len_r   [NREG];
  logic [EW_W-1:0] width_r [NREG];

  // One entry per architectural register; reset to scalar (R1).
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [VL_W-1:0] len_q;
    logic [EW_W-1:0] width_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q   <= VL_W'(1);
        width_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        len_q   <= wr_len;
        width_q <= wr_width;
      end
    end
    assign len_r[g]   = len_q;
    assign width_r[g] = width_q;
  end

  // Reads see the state after the last edge, so a write is used by the
  // next accepted instruction (R7).
  assign rd_len   = len_r[rd_idx];
  assign a_len    = len_r[a_idx];
  assign b_len    = len_r[b_idx];
  assign rd_width = width_r[rd_idx];

endmodule

// File: rtl/regrange_plan.sv
module regrange_plan
  import regrange_pkg::*;
#(
  parameter int NREG = 32,
  parameter int VL_W = 8,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] rd,
  input  logic [IDX_W-1:0] rs1,
  input  logic [IDX_W-1:0] rs2,
  input  logic [VL_W-1:0]  rd_len,
  input  logic [VL_W-1:0]  a_len,
  input  logic [VL_W-1:0]  b_len,
  output logic [CNT_W-1:0] count,
  output logic             vec_rd,
  output logic             vec_a,
  output logic             vec_b,
  output form_e            form,
  output logic             sub_b,
  output logic             illegal
);

  int unsigned l_rd, l_a, l_b, n;

  always_comb begin
    l_rd = eff_len(32'(rd_len));
    l_a  = eff_len(32'(a_len));
    l_b  = eff_len(32'(b_len));
    n    = max3(l_rd, l_a, l_b);          // R3
    vec_rd = (l_rd > 1);
    vec_a  = (l_a > 1);
    vec_b  = (l_b > 1);
    illegal = (vec_rd && !span_fits(32'(rd),  n, NREG)) ||
              (vec_a  && !span_fits(32'(rs1), n, NREG)) ||
              (vec_b  && !span_fits(32'(rs2), n, NREG));   // R8
    count = CNT_W'(n);
    if (n == 1)       form = FORM_SCALAR;
    else if (!vec_rd) form = FORM_REDUCE;                  // R6
    else              form = FORM_ELEMWISE;
    sub_b = !vec_b;   // the scalar slot takes the accumulator (R6)
  end

endmodule

// File: rtl/regrange_seq.sv
module regrange_seq
  import regrange_pkg::*;
#(
  parameter int NREG = 32,
  parameter int OP_W = 4,
  parameter int EW_W = 2,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             illegal,
  input  logic [CNT_W-1:0] count,
  input  logic             vec_rd,
  input  logic             vec_a,
  input  logic             vec_b,
  input  form_e            form,
  input  logic             sub_b,
  input  logic [IDX_W-1:0] rd,
  input  logic [IDX_W-1:0] rs1,
  input  logic [IDX_W-1:0] rs2,
  input  logic [OP_W-1:0]  op,
  input  logic [EW_W-1:0]  width,
  input  logic [NREG-1:0]  pred,
  output logic             active,
  output logic             done,
  output logic             err,
  output logic [IDX_W-1:0] elem_idx,
  output logic             run_reduce,
  output logic             run_rd_vec,
  output logic             uop_valid,
  output logic [OP_W-1:0]  uop_op,
  output logic [IDX_W-1:0] uop_rd,
  output logic [IDX_W-1:0] uop_rs1,
  output logic [IDX_W-1:0] uop_rs2,
  output logic [EW_W-1:0]  uop_width,
  output logic             uop_we
);

  logic             active_q, done_q, err_q;
  logic             red_q, subb_q, vrd_q, va_q, vb_q;
  logic [IDX_W-1:0] idx_q, rd_q, ra_q, rb_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OP_W-1:0]  op_q;
  logic [EW_W-1:0]  width_q;
  logic [NREG-1:0]  pred_q;
  logic             last_elem;

  assign last_elem = (({1'b0, idx_q} + CNT_W'(1)) == cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      red_q    <= 1'b0;
      subb_q   <= 1'b0;
      vrd_q    <= 1'b0;
      va_q     <= 1'b0;
      vb_q     <= 1'b0;
      idx_q    <= '0;
      rd_q     <= '0;
      ra_q     <= '0;
      rb_q     <= '0;
      cnt_q    <= '0;
      op_q     <= '0;
      width_q  <= '0;
      pred_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (fire) begin
        if (illegal) begin
          err_q <= 1'b1;                    // R8: rejected, stay idle
        end else begin
          active_q <= 1'b1;
          idx_q    <= '0;
          cnt_q    <= count;
          red_q    <= (form == FORM_REDUCE);
          subb_q   <= sub_b;
          vrd_q    <= vec_rd;
          va_q     <= vec_a;
          vb_q     <= vec_b;
          rd_q     <= rd;
          ra_q     <= rs1;
          rb_q     <= rs2;
          op_q     <= op;
          width_q  <= width;                // R11
          pred_q   <= pred;                 // R5
        end
      end else if (active_q) begin
        idx_q <= idx_q + 1'b1;              // R9: one element per cycle
        if (last_elem) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    uop_rd  = rd_q + (vrd_q ? idx_q : '0);   // R3
    uop_rs1 = ra_q + (va_q  ? idx_q : '0);   // R3, R4
    uop_rs2 = rb_q + (vb_q  ? idx_q : '0);
    if (red_q && (idx_q != '0)) begin        // R6: accumulate into rd
      if (subb_q) uop_rs2 = rd_q;
      else        uop_rs1 = rd_q;
    end
  end

  assign uop_valid  = active_q;
  assign uop_op     = op_q;
  assign uop_width  = width_q;
  assign uop_we     = active_q && pred_q[idx_q] && (uop_rd != '0);  // R5, R10
  assign active     = active_q;
  assign done       = done_q;
  assign err        = err_q;
  assign elem_idx   = idx_q;
  assign run_reduce = red_q;
  assign run_rd_vec = vrd_q;

endmodule

// File: rtl/regrange_issue.sv
module regrange_issue
  import regrange_pkg::*;
#(
  parameter int NREG = 32,
  parameter int VL_W = 8,
  parameter int EW_W = 2,
  parameter int OP_W = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_reg,
  input  logic [VL_W-1:0]  cfg_len,
  input  logic [EW_W-1:0]  cfg_width,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_rd,
  input  logic [IDX_W-1:0] in_rs1,
  input  logic [IDX_W-1:0] in_rs2,
  input  logic [OP_W-1:0]  in_op,
  input  logic [NREG-1:0]  in_pred,
  output logic             uop_valid,
  output logic [OP_W-1:0]  uop_op,
  output logic [IDX_W-1:0] uop_rd,
  output logic [IDX_W-1:0] uop_rs1,
  output logic [IDX_W-1:0] uop_rs2,
  output logic [EW_W-1:0]  uop_width,
  output logic             uop_we,
  output logic             busy,
  output logic             done,
  output logic             err
);

  logic [VL_W-1:0]  rd_len, a_len, b_len;
  logic [EW_W-1:0]  rd_width;
  logic [CNT_W-1:0] plan_count;
  logic             plan_vrd, plan_va, plan_vb, plan_subb, plan_illegal;
  form_e            plan_form;
  logic             acc_fire;
  logic             seq_active;
  logic [IDX_W-1:0] elem_idx;
  logic             run_reduce, run_rd_vec;

  regrange_cfg_table #(.NREG(NREG), .VL_W(VL_W), .EW_W(EW_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_reg), .wr_len(cfg_len), .wr_width(cfg_width),
    .rd_idx(in_rd), .a_idx(in_rs1), .b_idx(in_rs2),
    .rd_len(rd_len), .a_len(a_len), .b_len(b_len), .rd_width(rd_width)
  );

  regrange_plan #(.NREG(NREG), .VL_W(VL_W)) u_plan (
    .rd(in_rd), .rs1(in_rs1), .rs2(in_rs2),
    .rd_len(rd_len), .a_len(a_len), .b_len(b_len),
    .count(plan_count), .vec_rd(plan_vrd), .vec_a(plan_va), .vec_b(plan_vb),
    .form(plan_form), .sub_b(plan_subb), .illegal(plan_illegal)
  );

  assign in_ready = !seq_active;        // R9
  assign acc_fire = in_valid && in_ready;
  assign busy     = seq_active;

  regrange_seq #(.NREG(NREG), .OP_W(OP_W), .EW_W(EW_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .fire(acc_fire), .illegal(plan_illegal), .count(plan_count),
    .vec_rd(plan_vrd), .vec_a(plan_va), .vec_b(plan_vb),
    .form(plan_form), .sub_b(plan_subb),
    .rd(in_rd), .rs1(in_rs1), .rs2(in_rs2), .op(in_op), .width(rd_width), .pred(in_pred),
    .active(seq_active), .done(done), .err(err),
    .elem_idx(elem_idx), .run_reduce(run_reduce), .run_rd_vec(run_rd_vec),
    .uop_valid(uop_valid), .uop_op(uop_op), .uop_rd(uop_rd), .uop_rs1(uop_rs1),
    .uop_rs2(uop_rs2), .uop_width(uop_width), .uop_we(uop_we)
  );

endmodule

// File: rtl/regrange_checker.sv
module regrange_checker #(
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_fire,
  input logic             uop_valid,
  input logic [IDX_W-1:0] uop_rd,
  input logic             uop_we,
  input logic             done,
  input logic             err,
  input logic [IDX_W-1:0] elem_idx,
  input logic             run_reduce,
  input logic             run_rd_vec
);

  // R9: done closes a run of micro-ops
  a_r9_done_after_uop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(uop_valid) && !uop_valid));

  // R9: every accepted instruction answers in the next cycle
  a_r9_accept_answered: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (uop_valid || err));

  // R8: a rejected instruction produces nothing else
  a_r8_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!uop_valid && !done));

  // R3: a vector destination advances by one each element
  a_r3_rd_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && (elem_idx != '0) && run_rd_vec) |-> (uop_rd == IDX_W'($past(uop_rd) + 1'b1)));

  // R6: a reduction keeps one destination
  a_r6_rd_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && (elem_idx != '0) && run_reduce) |-> (uop_rd == $past(uop_rd)));

  // R10: r0 is never written
  a_r10_no_r0_write: assert property (@(posedge clk) disable iff (!rst_n)
    uop_we |-> (uop_valid && (uop_rd != '0)));

endmodule

bind regrange_issue regrange_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .uop_valid(uop_valid),
  .uop_rd(uop_rd), .uop_we(uop_we), .done(done), .err(err),
  .elem_idx(elem_idx), .run_reduce(run_reduce), .run_rd_vec(run_rd_vec)
);

// File: tb/tb_regrange_issue.sv
module tb_regrange_issue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_reg = '0;
  logic [7:0]  cfg_len = '0;
  logic [1:0]  cfg_width = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [3:0]  in_op = '0;
  logic [31:0] in_pred = '0;
  logic        uop_valid, uop_we, busy, done, err;
  logic [3:0]  uop_op;
  logic [4:0]  uop_rd, uop_rs1, uop_rs2;
  logic [1:0]  uop_width;

  always #2 clk = ~clk;   // 250 MHz

  regrange_issue dut (.*);

  typedef struct {
    bit v; int rd; int rs1; int rs2; int op; int ew; bit we; bit dn; bit er; string tag;
  } exp_t;

  exp_t exp_q[$];
  int   len_m[32];
  int   wid_m[32];
  int   n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Cycle-by-cycle comparison against the expectation queue
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      exp_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else begin
        e = '{v:0, rd:0, rs1:0, rs2:0, op:0, ew:0, we:0, dn:0, er:0, tag:"R9"};
      end
      chk(e.tag, "uop_valid", int'(uop_valid), int'(e.v));
      chk(e.tag, "done", int'(done), int'(e.dn));
      chk(e.tag, "err", int'(err), int'(e.er));
      if (e.v) begin
        chk(e.tag, "uop_rd", int'(uop_rd), e.rd);
        chk(e.tag, "uop_rs1", int'(uop_rs1), e.rs1);
        chk(e.tag, "uop_rs2", int'(uop_rs2), e.rs2);
        chk(e.tag, "uop_op", int'(uop_op), e.op);
        chk(e.tag, "uop_width", int'(uop_width), e.ew);
        chk(e.tag, "uop_we", int'(uop_we), int'(e.we));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  function automatic int efl(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  // Behavioural expectation for one accepted instruction
  task automatic model(input int rd, input int a, input int b, input int op,
                       input logic [31:0] pred, input string tag);
    int lr, la, lb, n;
    bit bad;
    lr = efl(len_m[rd]); la = efl(len_m[a]); lb = efl(len_m[b]);
    n = lr;
    if (la > n) n = la;
    if (lb > n) n = lb;
    bad = (lr > 1 && rd + n > 32) || (la > 1 && a + n > 32) || (lb > 1 && b + n > 32);
    if (bad) begin
      exp_q.push_back('{v:0, rd:0, rs1:0, rs2:0, op:0, ew:0, we:0, dn:0, er:1, tag:tag});
      return;
    end
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.v = 1; e.dn = 0; e.er = 0; e.tag = tag; e.op = op; e.ew = wid_m[rd];
      e.rd  = (lr > 1) ? rd + i : rd;
      e.rs1 = (la > 1) ? a + i : a;
      e.rs2 = (lb > 1) ? b + i : b;
      if (lr == 1 && n > 1 && i > 0) begin
        if (lb == 1) e.rs2 = rd; else e.rs1 = rd;
      end
      e.we = pred[i] && (e.rd != 0);
      exp_q.push_back(e);
    end
    exp_q.push_back('{v:0, rd:0, rs1:0, rs2:0, op:0, ew:0, we:0, dn:1, er:0, tag:tag});
  endtask

  task automatic send(input int rd, input int a, input int b, input int op,
                      input logic [31:0] pred, input string tag);
    while (exp_q.size() != 0) @(negedge clk);
    in_valid = 1'b1; in_rd = 5'(rd); in_rs1 = 5'(a); in_rs2 = 5'(b);
    in_op = 4'(op); in_pred = pred;
    @(posedge clk);
    model(rd, a, b, op, pred, tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic setcfg(input int r, input int l, input int w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_reg = 5'(r); cfg_len = 8'(l); cfg_width = 2'(w);
    @(posedge clk);
    len_m[r] = l; wid_m[r] = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin len_m[i] = 1; wid_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "uop_valid", int'(uop_valid), 0);

    // R2: plain scalar, R1 default config, R5 masked scalar
    send(3, 1, 2, 5, 32'hFFFF_FFFF, "R2");
    send(7, 9, 11, 6, 32'h0, "R5");

    // R3 / R11: vector-vector with element width on the destination
    setcfg(8, 4, 2);
    setcfg(16, 4, 1);
    setcfg(24, 4, 0);
    send(8, 16, 24, 1, 32'hFFFF_FFFF, "R3");
    // R4: scalar-vector and vector-scalar, back to back
    send(8, 4, 16, 2, 32'hFFFF_FFFF, "R4");
    send(8, 16, 4, 3, 32'hFFFF_FFFF, "R4");
    // R5: sparse predicate
    send(8, 16, 24, 4, 32'h0000_000A, "R5");
    // R3: differing lengths, count from the longest operand
    setcfg(16, 6, 1);
    send(8, 16, 24, 7, 32'hFFFF_FFFF, "R3");

    // R6: reductions in all three source arrangements
    send(5, 4, 16, 8, 32'hFFFF_FFFF, "R6");
    send(5, 16, 4, 9, 32'hFFFF_FFFF, "R6");
    send(5, 16, 24, 10, 32'h0000_003B, "R6");

    // R8: range runs off the file, then a legal instruction still works
    setcfg(30, 4, 0);
    send(1, 30, 2, 1, 32'hFFFF_FFFF, "R8");
    send(9, 10, 11, 1, 32'hFFFF_FFFF, "R8");
    setcfg(28, 3, 3);
    send(28, 1, 2, 2, 32'hFFFF_FFFF, "R8");

    // R3: stored length 0 reads as 1
    setcfg(6, 0, 1);
    send(6, 1, 2, 3, 32'hFFFF_FFFF, "R3");

    // R10: destination r0, scalar and as start of a vector
    send(0, 1, 2, 4, 32'hFFFF_FFFF, "R10");
    setcfg(0, 3, 0);
    send(0, 16, 24, 5, 32'hFFFF_FFFF, "R10");
    setcfg(0, 1, 0);

    // R7: write then use in the very next cycle
    setcfg(12, 3, 2);
    send(12, 1, 2, 6, 32'hFFFF_FFFF, "R7");
    // R7: write during a run does not disturb it
    send(8, 16, 24, 7, 32'hFFFF_FFFF, "R7");
    @(negedge clk);
    cfg_we = 1'b1; cfg_reg = 5'd16; cfg_len = 8'd2; cfg_width = 2'd0;
    @(posedge clk);
    len_m[16] = 2; wid_m[16] = 0;
    @(negedge clk);
    cfg_we = 1'b0;
    send(8, 16, 24, 8, 32'hFFFF_FFFF, "R7");

    // R9: an instruction offered while busy is ignored
    send(16, 16, 24, 9, 32'hFFFF_FFFF, "R9");
    @(negedge clk);
    chk("R9", "in_ready while busy", int'(in_ready), 0);
    in_valid = 1'b1; in_rd = 5'd3; in_rs1 = 5'd4; in_rs2 = 5'd5; in_op = 4'd15;
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    chk("R9", "idle after run", int'(busy), 0);

    drain();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule